// File: doc/BRIEF.md
# Indirect Power-Management Event Register Unit

This unit collects wake events from the ports of a switch and presents them to a host through a narrow, byte-wide register bus. The host never addresses the event registers directly. It first writes a space/target code into a select register, then writes a byte offset into an offset register, and then reads or writes a data window. These three direct registers give access to one 32-bit global control word and to one 32-bit status word per port. Bytes are ordered big-endian inside each word.

Each port status word holds three sticky flags: magic packet seen, link came up, and energy sensed. Single-cycle pulses from the event detectors set the flags. The host clears a flag by writing a one to it. A single wake pin combines every flag of every port. Two bits of the global word gate this pin and choose its active level.

Top module: `pme_indirect_regs`

## Requirements
- R1: After reset, every stored value is zero: the select byte, the offset byte, both global bits and every port flag. The host read data is 0x00. The wake pin sits at 1, because it is disabled and in active-low mode.
- R2: Direct address 0x6E holds the select byte and direct address 0x6F holds the offset byte. Both can be written, and both read back the full byte last written.
- R3: Read data appears on `host_rdata` in the cycle after a read strobe. In any cycle that follows a cycle with no read strobe, `host_rdata` is 0x00.
- R4: Direct address 0xA0 is the data window into the selected 32-bit word. Offset 0 gives bits [31:24], offset 1 gives [23:16], offset 2 gives [15:8] and offset 3 gives [7:0]. Every bit other than the defined ones reads as zero.
- R5: The global word is selected when select bits [7:5] are 3'b100 and bits [3:0] are 0. In that word, bit 1 enables the pin and bit 0 picks the polarity (1 means active-high). Both bits are read/write through offset 3. The global word changes only on a window write.
- R6: A select target n from 1 to NUM_PORTS reaches the status word of port n. In that word, bit 2 is set by a magic-packet pulse, bit 1 by a link-up pulse and bit 0 by an energy pulse. A flag reads as set in the cycle after its pulse.
- R7: Writing a port word at offset 3 clears each flag whose data bit is 1 and leaves the flags whose data bit is 0. A flag never clears without a window write.
- R8: An event pulse and a clearing write to the same flag in the same cycle leave the flag set.
- R9: Window reads return 0x00, and window writes change nothing, when the select space is not 3'b100, when the target is above NUM_PORTS, or when the offset is above 3.
- R10: While the pin is enabled and any flag of any port is set, the wake pin drives the active level: 1 when bit 0 of the global word is 1, 0 when it is 0. Otherwise the pin drives the inverse of bit 0.
- R11: Writes to any other direct address have no effect. Reads of any other direct address return 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| host_addr | input | 8 | Direct register address |
| host_wr | input | 1 | Write strobe |
| host_wdata | input | 8 | Write data |
| host_rd | input | 1 | Read strobe |
| host_rdata | output | 8 | Read data, valid the cycle after the strobe |
| evt_magic | input | NUM_PORTS | Magic-packet pulse, one bit per port |
| evt_link | input | NUM_PORTS | Link-up pulse, one bit per port |
| evt_energy | input | NUM_PORTS | Energy-detect pulse, one bit per port |
| pme_pin | output | 1 | Combined wake output |

## Verification
Some properties are checked on every cycle. An event pulse always leaves its flag set in the next cycle, including when a clear hits the same flag. A flag only falls after a window write. The global bits only change after a window write. Read data is zero after a cycle without a read. The wake pin rests at its inactive level while it is disabled or while no flag is set. Other behaviour can only be shown by the directed scenarios: the big-endian byte placement, the exact clear masks, the per-port routing of events, the rejection of bad select codes, targets and offsets, and the pin's active level once it is enabled with flags pending.

// File: rtl/pme_ind_pkg.sv
package pme_ind_pkg;
    localparam int BYTE_W = 8;
    localparam int EVT_W  = 3;
    localparam int CTRL_W = 2;

    localparam logic [BYTE_W-1:0] SEL_ADDR = 8'h6E;
    localparam logic [BYTE_W-1:0] OFS_ADDR = 8'h6F;
    localparam logic [BYTE_W-1:0] WIN_ADDR = 8'hA0;

    localparam logic [2:0] PME_SPACE = 3'b100;

    // byte offset of bits [7:0]; also the highest legal offset
    localparam logic [BYTE_W-1:0] LOW_OFS = 8'h03;

    // global control bit positions
    localparam int CTRL_EN  = 1;
    localparam int CTRL_POL = 0;

    typedef struct packed {
        logic [BYTE_W-1:0] sel;
        logic [BYTE_W-1:0] ofs;
        logic [CTRL_W-1:0] ctrl;
        logic [BYTE_W-1:0] rdata;
    } host_state_t;
endpackage

// File: rtl/pme_window_decode.sv
module pme_window_decode
    import pme_ind_pkg::*;
#(
    parameter int NUM_PORTS = 4
) (
    input  logic [2:0]           space,
    input  logic [3:0]           target,
    input  logic [BYTE_W-1:0]    ofs,
    output logic                 hit_global,
    output logic [NUM_PORTS-1:0] hit_port,
    output logic                 low_byte
);
    logic space_ok;
    logic ofs_ok;

    always_comb begin
        space_ok   = (space == PME_SPACE);
        ofs_ok     = (ofs <= LOW_OFS);
        low_byte   = space_ok && (ofs == LOW_OFS);
        hit_global = space_ok && ofs_ok && (target == 4'd0);
    end

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_hit
        localparam logic [3:0] TGT = 4'(p + 1);
        assign hit_port[p] = space_ok && ofs_ok && (target == TGT);
    end
endmodule

// File: rtl/pme_port_status.sv
module pme_port_status
    import pme_ind_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [EVT_W-1:0] evt,
    input  logic [EVT_W-1:0] clr,
    output logic [EVT_W-1:0] stat
);
    logic [EVT_W-1:0] stat_d, stat_q;

    // a new event overrides a clear in the same cycle
    always_comb begin
        stat_d = (stat_q & ~clr) | evt;
    end

    always_ff @(posedge clk) begin
        if (rst) stat_q <= '0;
        else     stat_q <= stat_d;
    end

    assign stat = stat_q;
endmodule

// File: rtl/pme_pin_drive.sv
module pme_pin_drive
    import pme_ind_pkg::*;
#(
    parameter int NUM_PORTS = 4
) (
    input  logic [CTRL_W-1:0]          ctrl,
    input  logic [NUM_PORTS*EVT_W-1:0] stat_all,
    output logic                       pin
);
    logic active;

    always_comb begin
        active = ctrl[CTRL_EN] && (|stat_all);
        pin    = active ? ctrl[CTRL_POL] : ~ctrl[CTRL_POL];
    end
endmodule

// File: rtl/pme_indirect_regs.sv
module pme_indirect_regs
    import pme_ind_pkg::*;
#(
    parameter int NUM_PORTS = 4
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [7:0]           host_addr,
    input  logic                 host_wr,
    input  logic [7:0]           host_wdata,
    input  logic                 host_rd,
    output logic [7:0]           host_rdata,
    input  logic [NUM_PORTS-1:0] evt_magic,
    input  logic [NUM_PORTS-1:0] evt_link,
    input  logic [NUM_PORTS-1:0] evt_energy,
    output logic                 pme_pin
);
    localparam int STAT_W = NUM_PORTS * EVT_W;

    host_state_t state_d, state_q;

    logic                 hit_global;
    logic [NUM_PORTS-1:0] hit_port;
    logic                 low_byte;
    logic                 win_wr;
    logic [STAT_W-1:0]    stat_all;
    logic [CTRL_W-1:0]    glb_ctrl;
    logic [BYTE_W-1:0]    win_rd;

    pme_window_decode #(.NUM_PORTS(NUM_PORTS)) u_dec (
        .space      (state_q.sel[7:5]),
        .target     (state_q.sel[3:0]),
        .ofs        (state_q.ofs),
        .hit_global (hit_global),
        .hit_port   (hit_port),
        .low_byte   (low_byte)
    );

    assign win_wr = host_wr && (host_addr == WIN_ADDR);

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
        logic [EVT_W-1:0] evt_p;
        logic [EVT_W-1:0] clr_p;
        assign evt_p = {evt_magic[p], evt_link[p], evt_energy[p]};
        assign clr_p = (win_wr && hit_port[p] && low_byte) ? host_wdata[EVT_W-1:0] : '0;
        pme_port_status u_stat (
            .clk  (clk),
            .rst  (rst),
            .evt  (evt_p),
            .clr  (clr_p),
            .stat (stat_all[p*EVT_W +: EVT_W])
        );
    end

    // window read byte: only offset 3 carries defined bits
    always_comb begin
        win_rd = '0;
        if (low_byte) begin
            if (hit_global) win_rd = {{(BYTE_W-CTRL_W){1'b0}}, state_q.ctrl};
            for (int p = 0; p < NUM_PORTS; p++) begin
                if (hit_port[p]) win_rd = {{(BYTE_W-EVT_W){1'b0}}, stat_all[p*EVT_W +: EVT_W]};
            end
        end
    end

    always_comb begin
        state_d       = state_q;
        state_d.rdata = '0;
        if (host_rd) begin
            case (host_addr)
                SEL_ADDR: state_d.rdata = state_q.sel;
                OFS_ADDR: state_d.rdata = state_q.ofs;
                WIN_ADDR: state_d.rdata = win_rd;
                default:  state_d.rdata = '0;
            endcase
        end
        if (host_wr) begin
            case (host_addr)
                SEL_ADDR: state_d.sel = host_wdata;
                OFS_ADDR: state_d.ofs = host_wdata;
                WIN_ADDR: if (hit_global && low_byte) state_d.ctrl = host_wdata[CTRL_W-1:0];
                default:  ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= '0;
        else     state_q <= state_d;
    end

    assign glb_ctrl   = state_q.ctrl;
    assign host_rdata = state_q.rdata;

    pme_pin_drive #(.NUM_PORTS(NUM_PORTS)) u_pin (
        .ctrl     (state_q.ctrl),
        .stat_all (stat_all),
        .pin      (pme_pin)
    );
endmodule

// File: rtl/pme_indirect_regs_chk.sv
module pme_indirect_regs_chk
    import pme_ind_pkg::*;
#(
    parameter int NUM_PORTS = 4
) (
    input logic                       clk,
    input logic                       rst,
    input logic [7:0]                 host_addr,
    input logic                       host_wr,
    input logic                       host_rd,
    input logic [7:0]                 host_rdata,
    input logic [NUM_PORTS-1:0]       evt_magic,
    input logic [NUM_PORTS-1:0]       evt_link,
    input logic [NUM_PORTS-1:0]       evt_energy,
    input logic [NUM_PORTS*EVT_W-1:0] stat_all,
    input logic [CTRL_W-1:0]          glb_ctrl,
    input logic                       pme_pin
);
    logic [NUM_PORTS*EVT_W-1:0] evt_all;

    always_comb begin
        for (int p = 0; p < NUM_PORTS; p++) begin
            evt_all[p*EVT_W +: EVT_W] = {evt_magic[p], evt_link[p], evt_energy[p]};
        end
    end

    assert_rdata_idle_R3: assert property (@(posedge clk) disable iff (rst)
        !host_rd |=> host_rdata == 8'h00);

    assert_ctrl_hold_R5: assert property (@(posedge clk) disable iff (rst)
        !(host_wr && host_addr == WIN_ADDR) |=> $stable(glb_ctrl));

    for (genvar b = 0; b < NUM_PORTS*EVT_W; b++) begin : g_bit
        // R8: the event wins even against a clear in the same cycle
        assert_evt_sets_R6: assert property (@(posedge clk) disable iff (rst)
            evt_all[b] |=> stat_all[b]);

        assert_clear_needs_write_R7: assert property (@(posedge clk) disable iff (rst)
            $fell(stat_all[b]) |-> $past(host_wr && host_addr == WIN_ADDR));
    end

    assert_pin_disabled_R10: assert property (@(posedge clk) disable iff (rst)
        !glb_ctrl[CTRL_EN] |-> pme_pin == !glb_ctrl[CTRL_POL]);

    assert_pin_quiet_R10: assert property (@(posedge clk) disable iff (rst)
        (stat_all == '0) |-> pme_pin == !glb_ctrl[CTRL_POL]);
endmodule

bind pme_indirect_regs pme_indirect_regs_chk #(.NUM_PORTS(NUM_PORTS)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .host_addr  (host_addr),
    .host_wr    (host_wr),
    .host_rd    (host_rd),
    .host_rdata (host_rdata),
    .evt_magic  (evt_magic),
    .evt_link   (evt_link),
    .evt_energy (evt_energy),
    .stat_all   (stat_all),
    .glb_ctrl   (glb_ctrl),
    .pme_pin    (pme_pin)
);

// File: tb/pme_indirect_regs_test.sv
module pme_indirect_regs_test;
    localparam int NP = 4;
    localparam logic [7:0] A_SEL = 8'h6E;
    localparam logic [7:0] A_OFS = 8'h6F;
    localparam logic [7:0] A_WIN = 8'hA0;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [7:0]    host_addr = '0;
    logic          host_wr = 1'b0;
    logic [7:0]    host_wdata = '0;
    logic          host_rd = 1'b0;
    logic [7:0]    host_rdata;
    logic [NP-1:0] evt_magic = '0;
    logic [NP-1:0] evt_link = '0;
    logic [NP-1:0] evt_energy = '0;
    logic          pme_pin;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    pme_indirect_regs #(.NUM_PORTS(NP)) uut (
        .clk(clk), .rst(rst), .host_addr(host_addr), .host_wr(host_wr),
        .host_wdata(host_wdata), .host_rd(host_rd), .host_rdata(host_rdata),
        .evt_magic(evt_magic), .evt_link(evt_link), .evt_energy(evt_energy),
        .pme_pin(pme_pin)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=0x%02h expected=0x%02h", req, act, exp);
        end
    endtask

    task automatic do_wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        host_addr = a; host_wdata = d; host_wr = 1'b1;
        @(negedge clk);
        host_wr = 1'b0;
    endtask

    task automatic do_rd(input logic [7:0] a, output logic [7:0] d);
        @(negedge clk);
        host_addr = a; host_rd = 1'b1;
        @(negedge clk);
        host_rd = 1'b0;
        d = host_rdata;
    endtask

    task automatic point(input logic [7:0] sel, input logic [7:0] ofs);
        do_wr(A_SEL, sel);
        do_wr(A_OFS, ofs);
    endtask

    // kind: 2 magic, 1 link, 0 energy
    task automatic pulse(input int kind, input int port);
        @(negedge clk);
        case (kind)
            2: evt_magic[port] = 1'b1;
            1: evt_link[port] = 1'b1;
            default: evt_energy[port] = 1'b1;
        endcase
        @(negedge clk);
        evt_magic = '0; evt_link = '0; evt_energy = '0;
    endtask

    task automatic t_reset();
        logic [7:0] v;
        check("R1 pin", {7'b0, pme_pin}, 8'h01);
        check("R1 rdata", host_rdata, 8'h00);
        do_rd(A_SEL, v); check("R1 sel", v, 8'h00);
        do_rd(A_OFS, v); check("R1 ofs", v, 8'h00);
        point(8'h80, 8'h03);
        do_rd(A_WIN, v); check("R1 global", v, 8'h00);
        for (int p = 1; p <= NP; p++) begin
            do_wr(A_SEL, 8'h80 | 8'(p));
            do_rd(A_WIN, v); check("R1 port", v, 8'h00);
        end
    endtask

    task automatic t_direct();
        logic [7:0] v;
        do_wr(A_SEL, 8'h5A); do_rd(A_SEL, v); check("R2 sel", v, 8'h5A);
        do_wr(A_OFS, 8'hC3); do_rd(A_OFS, v); check("R2 ofs", v, 8'hC3);
        @(negedge clk); check("R3 idle rdata", host_rdata, 8'h00);
    endtask

    task automatic t_global();
        logic [7:0] v;
        point(8'h80, 8'h03);
        do_wr(A_WIN, 8'hFE);
        do_rd(A_WIN, v); check("R5 global write", v, 8'h02);
        for (int o = 0; o < 3; o++) begin
            do_wr(A_OFS, 8'(o));
            do_rd(A_WIN, v); check("R4 upper byte", v, 8'h00);
        end
        do_wr(A_OFS, 8'h03);
        do_wr(A_WIN, 8'h00);
        do_rd(A_WIN, v); check("R5 global clear", v, 8'h00);
    endtask

    task automatic t_events();
        logic [7:0] v;
        for (int p = 0; p < NP; p++) begin
            for (int k = 0; k < 3; k++) begin
                pulse(k, p);
                point(8'h80 | 8'(p + 1), 8'h03);
                do_rd(A_WIN, v); check("R6 event bit", v, 8'(1 << k));
                do_wr(A_OFS, 8'h00);
                do_rd(A_WIN, v); check("R4 byte 0 zero", v, 8'h00);
                do_wr(A_SEL, 8'h80 | 8'(((p + 1) % NP) + 1));
                do_wr(A_OFS, 8'h03);
                do_rd(A_WIN, v); check("R6 other port", v, 8'h00);
                do_wr(A_SEL, 8'h80 | 8'(p + 1));
                do_wr(A_WIN, 8'(1 << k));
                do_rd(A_WIN, v); check("R7 cleared", v, 8'h00);
            end
        end
    endtask

    task automatic t_w1c();
        logic [7:0] v;
        pulse(2, 0); pulse(1, 0); pulse(0, 0);
        point(8'h81, 8'h03);
        do_rd(A_WIN, v); check("R6 all three", v, 8'h07);
        do_wr(A_WIN, 8'h00);
        do_rd(A_WIN, v); check("R7 zero write keeps", v, 8'h07);
        do_wr(A_WIN, 8'h02);
        do_rd(A_WIN, v); check("R7 partial clear", v, 8'h05);
        do_wr(A_WIN, 8'hFD);
        do_rd(A_WIN, v); check("R7 rest clear", v, 8'h00);
    endtask

    task automatic t_collide();
        logic [7:0] v;
        pulse(1, 1);
        point(8'h82, 8'h03);
        @(negedge clk);
        host_addr = A_WIN; host_wdata = 8'h02; host_wr = 1'b1; evt_link[1] = 1'b1;
        @(negedge clk);
        host_wr = 1'b0; evt_link = '0;
        do_rd(A_WIN, v); check("R8 event wins", v, 8'h02);
        do_wr(A_WIN, 8'h02);
        do_rd(A_WIN, v); check("R8 later clear", v, 8'h00);
    endtask

    task automatic t_invalid();
        logic [7:0] v;
        pulse(0, 0);
        point(8'h61, 8'h03);
        do_rd(A_WIN, v); check("R9 bad space read", v, 8'h00);
        do_wr(A_WIN, 8'h01);
        do_wr(A_SEL, 8'h85);
        do_rd(A_WIN, v); check("R9 bad target read", v, 8'h00);
        do_wr(A_WIN, 8'h01);
        point(8'h81, 8'h04);
        do_rd(A_WIN, v); check("R9 bad offset read", v, 8'h00);
        do_wr(A_WIN, 8'hFF);
        do_wr(A_OFS, 8'h03);
        do_rd(A_WIN, v); check("R9 flag survives", v, 8'h01);
        do_wr(A_WIN, 8'h01);
        point(8'h40, 8'h03);
        do_wr(A_WIN, 8'h03);
        point(8'h80, 8'h07);
        do_wr(A_WIN, 8'h03);
        do_wr(A_OFS, 8'h03);
        do_rd(A_WIN, v); check("R9 global untouched", v, 8'h00);
    endtask

    task automatic t_pin();
        point(8'h80, 8'h03);
        @(negedge clk); check("R10 off low-pol", {7'b0, pme_pin}, 8'h01);
        do_wr(A_WIN, 8'h01);
        @(negedge clk); check("R10 off high-pol", {7'b0, pme_pin}, 8'h00);
        do_wr(A_WIN, 8'h03);
        @(negedge clk); check("R10 on no flag", {7'b0, pme_pin}, 8'h00);
        pulse(2, 3);
        check("R10 on high active", {7'b0, pme_pin}, 8'h01);
        do_wr(A_WIN, 8'h02);
        @(negedge clk); check("R10 on low active", {7'b0, pme_pin}, 8'h00);
        do_wr(A_WIN, 8'h00);
        @(negedge clk); check("R10 disabled pending", {7'b0, pme_pin}, 8'h01);
        do_wr(A_WIN, 8'h02);
        point(8'h84, 8'h03);
        do_wr(A_WIN, 8'h04);
        @(negedge clk); check("R10 flags cleared", {7'b0, pme_pin}, 8'h01);
        point(8'h80, 8'h03);
        do_wr(A_WIN, 8'h00);
    endtask

    task automatic t_other();
        logic [7:0] v;
        do_wr(A_SEL, 8'h81);
        do_wr(8'h10, 8'h33);
        do_rd(8'h10, v); check("R11 other read", v, 8'h00);
        do_wr(8'h6D, 8'h99);
        do_rd(A_SEL, v); check("R11 sel kept", v, 8'h81);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_direct();
        t_global();
        t_events();
        t_w1c();
        t_collide();
        t_invalid();
        t_pin();
        t_other();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule